// File: doc/BRIEF.md
# Debug Probe Startup Sequencer

This controller takes a target processor from reset to a known debug state. It drives the target's active-low hard-reset line and holds a debug-entry request. It detects when the target has frozen, and then follows one of three startup modes. In the first mode the target is initialised at once. In the second, the target runs its own boot code for a programmable delay before it is halted and initialised. In the third, the target is released and left running until the host asks for a halt.

Initialisation is a short list of address/value/size entries kept in an internal table. Each entry is handed to an external debug-port engine as a write request, and the engine acknowledges it. Freeze is normally read from two status pins. When only the first pin reads high, the block asks the debug port for the target's status and relies on the answer. A timeout on every debug-entry attempt makes the sequence end with an error flag instead of hanging.

Top module: `dbg_startup_seq`

## Requirements
- R1: One cycle after `start` is accepted in idle, `hreset_n` goes low for exactly `RST_CYC` cycles. `brk_req` is never high while `hreset_n` is low, and `brk_req` rises in the cycle `hreset_n` is released.
- R2: While `brk_req` is high, the target is taken as frozen when `frz_a` and `frz_b` are both 1. No status query is issued in that case, and `frozen` goes high.
- R3: While `brk_req` is high and `frz_a`=1 with `frz_b`=0, the pins alone never declare freeze. Instead `qry_req` is raised and held until `qry_ack`, and freeze is declared only if `qry_frozen` is 1 in the acknowledge cycle.
- R4: Mode code 0 (codes 0 and 3 both select it): after freeze, the list is written with no restart. Entry k, for k = 0 to `LIST_LEN`-1 in order, has address 32'h0000_1000+4k, data 32'hC3A5_0000+k and `wr_size` = k mod 3 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit). Entry `LIST_LEN`-1 ends the list. `wr_req` holds each entry until `wr_ack`.
- R5: Mode code 1: after the first freeze, `resume` pulses for one cycle and no write is issued. `brk_req` rises again exactly `RUN_DELAY_CYC`+1 cycles after the `resume` cycle, and after that second freeze the list of R4 is written.
- R6: Mode code 2: after the first freeze, `resume` pulses and no list write is ever issued. `brk_req` stays low until `halt_req` is seen, then rises, and the following freeze sets `frozen`.
- R7: If no freeze is seen while `brk_req` has been high for `FRZ_TIMEOUT_CYC` cycles, `brk_req` drops and `error` goes high. There is no `done` and no write.
- R8: `done` is a single-cycle pulse, once per sequence. It comes one cycle after the last list write is acknowledged (codes 0 and 1), or one cycle after the `resume` pulse (code 2).
- R9: `mode` is sampled only in the cycle `start` is accepted. Changing it later has no effect on the running sequence.
- R10: `frozen` clears in the cycle after `resume` and whenever a new sequence starts. `error` clears when a new sequence starts.
- R11: After reset, `hreset_n`=1 and `brk_req`, `resume`, `qry_req`, `wr_req`, `done`, `frozen` and `error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a startup sequence (accepted in idle) |
| mode | input | 2 | Startup mode code: 0 init, 1 delayed halt, 2 run |
| halt_req | input | 1 | Host halt request while target runs (mode 2) |
| frz_a | input | 1 | First freeze-status pin |
| frz_b | input | 1 | Second freeze-status pin |
| qry_ack | input | 1 | Debug-port status query answered |
| qry_frozen | input | 1 | Query answer: target is frozen |
| wr_ack | input | 1 | Debug-port write accepted |
| hreset_n | output | 1 | Active-low hard reset to target |
| brk_req | output | 1 | Force debug entry |
| resume | output | 1 | One-cycle restart of the target |
| qry_req | output | 1 | Debug-port status query request |
| wr_req | output | 1 | Init-list write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_size | output | 2 | Write size code |
| done | output | 1 | Sequence finished pulse |
| frozen | output | 1 | Target held in debug mode |
| error | output | 1 | Freeze timeout occurred |

## Verification
Most results are checked as measured counts and cycle gaps, not at fixed cycle numbers. These are the reset-low cycle count (`RST_CYC`), the gap from `resume` to the renewed `brk_req` (`RUN_DELAY_CYC`+1), and the number of `brk_req` cycles before a timeout (`FRZ_TIMEOUT_CYC`). A monitor samples every output on the falling clock edge, half a cycle after the registered state has settled, so each measured edge lands in the cycle in which it is due. Status results such as `done`, `frozen` and `error` are registered one cycle after their cause. They are read only once the sequence has ended plus a few settling cycles, and the write log is compared entry by entry with the address/data/size formula.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] LIST_BASE = 32'h0000_1000;
    localparam logic [DATA_W-1:0] DATA_SEED = 32'hC3A5_0000;

    typedef enum logic [1:0] {
        SM_INIT  = 2'd0,
        SM_DELAY = 2'd1,
        SM_RUN   = 2'd2
    } start_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef struct packed {
        logic              last;
        xfer_size_e        size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } init_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HRST,
        S_ENTRY,
        S_RESUME,
        S_DELAY,
        S_RUNNING,
        S_LIST
    } seq_state_e;

    function automatic start_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return SM_DELAY;
            2'd2:    return SM_RUN;
            default: return SM_INIT;
        endcase
    endfunction

    function automatic init_entry_t make_entry(input int unsigned idx, input int unsigned len);
        init_entry_t e;
        e.addr = LIST_BASE + ADDR_W'(idx * 4);
        e.data = DATA_SEED + DATA_W'(idx);
        case (idx % 3)
            0:       e.size = SZ_BYTE;
            1:       e.size = SZ_HALF;
            default: e.size = SZ_WORD;
        endcase
        e.last = (idx == len - 1);
        return e;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dbg_init_rom.sv
module dbg_init_rom
    import dbg_seq_pkg::*;
#(
    parameter int LIST_LEN = 4,
    parameter int IDX_W    = 2
) (
    input  logic [IDX_W-1:0] idx,
    output init_entry_t      entry
);

    init_entry_t rows [LIST_LEN];

    for (genvar g = 0; g < LIST_LEN; g++) begin : g_row
        assign rows[g] = make_entry(32'(g), 32'(LIST_LEN));
    end

    assign entry = (int'(idx) < LIST_LEN) ? rows[idx] : rows[LIST_LEN-1];

endmodule

// File: rtl/dbg_cyc_timer.sv
module dbg_cyc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dbg_frz_det.sv
module dbg_frz_det (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic frz_a,
    input  logic frz_b,
    input  logic qry_ack,
    input  logic qry_frozen,
    output logic qry_req,
    output logic hit
);

    logic q_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            q_q <= 1'b0;
        end else if (q_q && qry_ack) begin
            q_q <= 1'b0;
        end else if (!q_q && frz_a && !frz_b) begin
            q_q <= 1'b1;
        end
    end

    assign qry_req = q_q;
    assign hit     = en && ((frz_a && frz_b) || (q_q && qry_ack && qry_frozen));

endmodule

// File: rtl/dbg_startup_seq.sv
module dbg_startup_seq
    import dbg_seq_pkg::*;
#(
    parameter int RST_CYC         = 16,
    parameter int RUN_DELAY_CYC   = 200_000_000,
    parameter int FRZ_TIMEOUT_CYC = 1024,
    parameter int LIST_LEN        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              halt_req,
    input  logic              frz_a,
    input  logic              frz_b,
    input  logic              qry_ack,
    input  logic              qry_frozen,
    input  logic              wr_ack,
    output logic              hreset_n,
    output logic              brk_req,
    output logic              resume,
    output logic              qry_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [1:0]        wr_size,
    output logic              done,
    output logic              frozen,
    output logic              error
);

    localparam int IDX_W   = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1;
    localparam int MAX_CYC = int'(max3(RST_CYC, RUN_DELAY_CYC, FRZ_TIMEOUT_CYC));
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    seq_state_e       st_q, st_d;
    start_mode_e      mode_q;
    logic             second_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q, frz_q, err_q;
    logic             tmr_load, tmr_zero, frz_hit;
    logic [TMR_W-1:0] tmr_val;
    init_entry_t      cur;

    dbg_init_rom #(.LIST_LEN(LIST_LEN), .IDX_W(IDX_W)) u_rom (
        .idx   (idx_q),
        .entry (cur)
    );

    dbg_cyc_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dbg_frz_det u_det (
        .clk        (clk),
        .rst        (rst),
        .en         (st_q == S_ENTRY),
        .frz_a      (frz_a),
        .frz_b      (frz_b),
        .qry_ack    (qry_ack),
        .qry_frozen (qry_frozen),
        .qry_req    (qry_req),
        .hit        (frz_hit)
    );

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            S_IDLE: if (start) begin
                st_d     = S_HRST;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RST_CYC - 1);
            end
            S_HRST: if (tmr_zero) begin
                st_d     = S_ENTRY;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(FRZ_TIMEOUT_CYC - 1);
            end
            S_ENTRY: begin
                if (frz_hit) begin
                    if (second_q) st_d = (mode_q == SM_RUN) ? S_IDLE : S_LIST;
                    else          st_d = (mode_q == SM_INIT) ? S_LIST : S_RESUME;
                end else if (tmr_zero) begin
                    st_d = S_IDLE;
                end
            end
            S_RESUME: begin
                if (mode_q == SM_DELAY) begin
                    st_d     = S_DELAY;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RUN_DELAY_CYC - 1);
                end else begin
                    st_d = S_RUNNING;
                end
            end
            S_DELAY: if (tmr_zero) begin
                st_d     = S_ENTRY;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(FRZ_TIMEOUT_CYC - 1);
            end
            S_RUNNING: if (halt_req) begin
                st_d     = S_ENTRY;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(FRZ_TIMEOUT_CYC - 1);
            end
            S_LIST: if (wr_ack && cur.last) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            mode_q   <= SM_INIT;
            second_q <= 1'b0;
            idx_q    <= '0;
            done_q   <= 1'b0;
            frz_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    mode_q   <= decode_mode(mode);
                    second_q <= 1'b0;
                    idx_q    <= '0;
                    frz_q    <= 1'b0;
                    err_q    <= 1'b0;
                end
                S_ENTRY: begin
                    if (frz_hit)       frz_q <= 1'b1;
                    else if (tmr_zero) err_q <= 1'b1;
                end
                S_RESUME: begin
                    frz_q <= 1'b0;
                    if (mode_q == SM_RUN) done_q <= 1'b1;
                end
                S_DELAY:   if (tmr_zero) second_q <= 1'b1;
                S_RUNNING: if (halt_req) second_q <= 1'b1;
                S_LIST: if (wr_ack) begin
                    if (cur.last) done_q <= 1'b1;
                    else          idx_q  <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign hreset_n = (st_q != S_HRST);
    assign brk_req  = (st_q == S_ENTRY);
    assign resume   = (st_q == S_RESUME);
    assign wr_req   = (st_q == S_LIST);
    assign wr_addr  = cur.addr;
    assign wr_data  = cur.data;
    assign wr_size  = cur.size;
    assign done     = done_q;
    assign frozen   = frz_q;
    assign error    = err_q;

endmodule

// File: rtl/dbg_startup_seq_chk.sv
module dbg_startup_seq_chk (
    input logic clk,
    input logic rst,
    input logic hreset_n,
    input logic brk_req,
    input logic resume,
    input logic qry_req,
    input logic wr_req,
    input logic done,
    input logic frozen,
    input logic error,
    input logic frz_a,
    input logic frz_b
);

    AST_NO_BRK_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !hreset_n |-> !brk_req); // R1

    AST_FREEZE_FROM_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(frozen) |-> $past(brk_req)); // R2

    AST_QUERY_ON_SPLIT_PINS: assert property (@(posedge clk) disable iff (rst)
        $rose(qry_req) |-> ($past(frz_a) && !$past(frz_b))); // R3

    AST_WRITE_WHILE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> frozen); // R4

    AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (rst)
        error |-> (!brk_req && !wr_req && !done)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_RESUME_UNFREEZE: assert property (@(posedge clk) disable iff (rst)
        resume |=> !frozen); // R10

endmodule

bind dbg_startup_seq dbg_startup_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .hreset_n (hreset_n),
    .brk_req  (brk_req),
    .resume   (resume),
    .qry_req  (qry_req),
    .wr_req   (wr_req),
    .done     (done),
    .frozen   (frozen),
    .error    (error),
    .frz_a    (frz_a),
    .frz_b    (frz_b)
);

// File: tb/test_dbg_startup_seq.sv
module test_dbg_startup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 4;
    localparam int DLY        = 40;
    localparam int TO         = 30;
    localparam int LEN        = 5;
    localparam int FRZ_LAT    = 3;
    localparam int WDOG       = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic halt_req = 1'b0;
    logic frz_a, frz_b;
    logic qry_ack = 1'b0;
    logic qry_frozen = 1'b0;
    logic wr_ack = 1'b0;
    logic hreset_n, brk_req, resume, qry_req, wr_req, done, frozen, error;
    logic [31:0] wr_addr, wr_data;
    logic [1:0]  wr_size;

    // target model controls
    logic tgt_frz = 1'b0;
    logic tgt_live = 1'b1;
    logic wire_b = 1'b1;
    logic q_deny = 1'b0;
    int   lat = 0;

    // monitor
    logic clr = 1'b0;
    int cyc = 0;
    int n_hrst = 0, n_brk = 0, n_res = 0, n_done = 0, n_qry = 0, n_wr = 0;
    int cyc_res = 0, cyc_brk2 = 0, wr_at_brk2 = 0;
    logic brk_prev = 1'b0, qry_prev = 1'b0;
    logic [31:0] log_addr [8];
    logic [31:0] log_data [8];
    logic [1:0]  log_size [8];

    int n_checks = 0;
    int n_err = 0;

    assign frz_a = tgt_frz;
    assign frz_b = tgt_frz && wire_b;

    dbg_startup_seq #(
        .RST_CYC(RST_CYC), .RUN_DELAY_CYC(DLY),
        .FRZ_TIMEOUT_CYC(TO), .LIST_LEN(LEN)
    ) i_dbg_startup_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .halt_req(halt_req),
        .frz_a(frz_a), .frz_b(frz_b), .qry_ack(qry_ack), .qry_frozen(qry_frozen),
        .wr_ack(wr_ack), .hreset_n(hreset_n), .brk_req(brk_req), .resume(resume),
        .qry_req(qry_req), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_size(wr_size), .done(done), .frozen(frozen), .error(error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            tgt_frz <= 1'b0; lat <= 0; qry_ack <= 1'b0; wr_ack <= 1'b0;
        end else begin
            if (!hreset_n || resume) begin
                tgt_frz <= 1'b0; lat <= 0;
            end else if (brk_req && tgt_live && !tgt_frz) begin
                if (lat == FRZ_LAT - 1) begin tgt_frz <= 1'b1; lat <= 0; end
                else lat <= lat + 1;
            end
            qry_ack    <= qry_req && !qry_ack;
            qry_frozen <= tgt_frz && !q_deny;
            wr_ack     <= wr_req && !wr_ack;
        end
        if (clr) begin
            n_hrst <= 0; n_brk <= 0; n_res <= 0; n_done <= 0; n_qry <= 0; n_wr <= 0;
            cyc_res <= 0; cyc_brk2 <= 0; wr_at_brk2 <= 0;
        end else begin
            if (!hreset_n) n_hrst <= n_hrst + 1;
            if (brk_req) n_brk <= n_brk + 1;
            if (resume) begin n_res <= n_res + 1; cyc_res <= cyc; end
            if (brk_req && !brk_prev && n_res > 0 && cyc_brk2 == 0) begin
                cyc_brk2 <= cyc; wr_at_brk2 <= n_wr;
            end
            if (done) n_done <= n_done + 1;
            if (qry_req && !qry_prev) n_qry <= n_qry + 1;
            if (wr_req && !wr_ack && !rst) begin
                if (n_wr < 8) begin
                    log_addr[n_wr] <= wr_addr;
                    log_data[n_wr] <= wr_data;
                    log_size[n_wr] <= wr_size;
                end
                n_wr <= n_wr + 1;
            end
        end
        brk_prev <= brk_req;
        qry_prev <= qry_req;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic kick(input int m);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; mode = 2'(m); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done || error) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_list(input string req);
        check(n_wr == LEN, req, "write count", n_wr, LEN);
        for (int k = 0; k < LEN; k++) begin
            check(log_addr[k] == 32'h0000_1000 + 32'(4 * k), req, "write addr", log_addr[k],
                  32'h0000_1000 + 32'(4 * k));
            check(log_data[k] == 32'hC3A5_0000 + 32'(k), req, "write data", log_data[k],
                  32'hC3A5_0000 + 32'(k));
            check(log_size[k] == 2'(k % 3), req, "write size", log_size[k], k % 3);
        end
    endtask

    task automatic t_reset_state;
        check(hreset_n == 1'b1, "R11", "hreset_n", hreset_n, 1);
        check(!brk_req && !resume && !qry_req, "R11", "brk/resume/qry", {brk_req, resume, qry_req}, 0);
        check(!wr_req && !done, "R11", "wr_req/done", {wr_req, done}, 0);
        check(!frozen && !error, "R11", "frozen/error", {frozen, error}, 0);
    endtask

    task automatic t_init_mode;
        kick(0);
        wait_end(500);
        check(n_hrst == RST_CYC, "R1", "hreset low cycles", n_hrst, RST_CYC);
        check(n_qry == 0, "R2", "queries with both pins", n_qry, 0);
        check(frozen == 1'b1, "R2", "frozen", frozen, 1);
        check(n_res == 0, "R4", "restarts in init mode", n_res, 0);
        check_list("R4");
        check(n_done == 1, "R8", "done pulses", n_done, 1);
    endtask

    task automatic t_delay_mode;
        kick(1);
        check(frozen == 1'b0, "R10", "frozen cleared at new start", frozen, 0);
        wait_end(1000);
        check(n_res == 1, "R5", "resume pulses", n_res, 1);
        check(cyc_brk2 - cyc_res == DLY + 1, "R5", "resume to re-entry gap",
              cyc_brk2 - cyc_res, DLY + 1);
        check(wr_at_brk2 == 0, "R5", "writes before re-entry", wr_at_brk2, 0);
        check_list("R5");
        check(n_done == 1, "R8", "done pulses", n_done, 1);
        check(frozen == 1'b1, "R5", "frozen at end", frozen, 1);
    endtask

    task automatic t_run_mode;
        int brk_before;
        kick(2);
        wait_end(500);
        check(n_res == 1, "R6", "resume pulses", n_res, 1);
        check(frozen == 1'b0, "R10", "frozen after resume", frozen, 0);
        check(n_done == 1, "R8", "done after resume", n_done, 1);
        brk_before = n_brk;
        repeat (60) @(negedge clk);
        check(n_brk == brk_before && !brk_req, "R6", "brk while running", n_brk, brk_before);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (frozen) break;
        end
        check(frozen == 1'b1, "R6", "frozen after halt", frozen, 1);
        check(n_wr == 0, "R6", "writes in run mode", n_wr, 0);
        check(n_done == 1, "R8", "done count after halt", n_done, 1);
    endtask

    task automatic t_query_yes;
        wire_b = 1'b0;
        kick(0);
        wait_end(500);
        check(n_qry >= 1, "R3", "status queries", n_qry, 1);
        check(frozen == 1'b1 && error == 1'b0, "R3", "frozen via query", {frozen, error}, 2);
        check(n_wr == LEN, "R3", "writes after query freeze", n_wr, LEN);
        wire_b = 1'b1;
    endtask

    task automatic t_query_no;
        wire_b = 1'b0;
        q_deny = 1'b1;
        kick(0);
        wait_end(500);
        check(n_qry >= 1, "R3", "queries issued", n_qry, 1);
        check(frozen == 1'b0, "R3", "no freeze from pins alone", frozen, 0);
        check(error == 1'b1, "R7", "error after denied queries", error, 1);
        check(n_wr == 0, "R7", "writes after denial", n_wr, 0);
        wire_b = 1'b1;
        q_deny = 1'b0;
    endtask

    task automatic t_timeout;
        tgt_live = 1'b0;
        kick(0);
        wait_end(500);
        check(error == 1'b1, "R7", "error flag", error, 1);
        check(n_brk == TO, "R7", "brk cycles before timeout", n_brk, TO);
        check(brk_req == 1'b0, "R7", "brk after timeout", brk_req, 0);
        check(n_done == 0 && n_wr == 0, "R7", "done/writes", n_done + n_wr, 0);
        tgt_live = 1'b1;
        kick(0);
        check(error == 1'b0, "R10", "error cleared at start", error, 1'b0);
        wait_end(500);
        check(error == 1'b0 && n_wr == LEN, "R10", "clean rerun", n_wr, LEN);
    endtask

    task automatic t_mode_latch;
        kick(1);
        mode = 2'd2;
        wait_end(1000);
        check(n_res == 1, "R9", "resume count", n_res, 1);
        check(n_wr == LEN, "R9", "list written despite mode change", n_wr, LEN);
        mode = 2'd0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", WDOG, WDOG);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_init_mode();
        t_delay_mode();
        t_run_mode();
        t_query_yes();
        t_query_no();
        t_timeout();
        t_mode_latch();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule